// File: doc/BRIEF.md
# Write-Triggered Indirect Read Unit

This block sits between a host register bus and a block of internal registers. Normally a host write to the internal register space passes straight through as a write. Each of two access paths, a buffered one and an unbuffered one, has a mode flag. While a path's flag is set, a host write to that path's register space does not write anything. It launches a read of the addressed register instead. The value that comes back is held in that path's read-data register, and a two-bit readiness code in a shared status word tells the host whether a single or a double word is waiting.

The usual sequence is to set the mode flag with an opcode write to the path's control register, then write any value (all-ones by habit) to the register of interest. The host then polls the status word until the readiness code is non-zero, and reads the result. The internal register port is modelled with a variable latency. Requests carry a tag made of the path number and a per-path sequence count, and a response is accepted only when its tag belongs to the newest request of its path. A later request therefore always supersedes an earlier one, even when the earlier one is still in flight.

Host address decode, with AW address bits:
- `host_addr[AW-1]` = 1 selects the unit's own registers, at local offset `host_addr[2:0]`.
- `host_addr[AW-1]` = 0 selects the internal register space. `host_addr[AW-2]` then picks the path (0 buffered, 1 unbuffered), and `host_addr[AW-3:0]` is the register address.

Top module: `wtr_read_unit`

## Requirements
- R1: After reset, both mode flags are 0, the status word reads 0 and every read-data word reads 0.
- R2: Control registers sit at local offset 1 (buffered) and 2 (unbuffered). A write takes its opcode from `host_wdata[2:1]`: opcode 3 sets the path's mode flag, opcode 2 clears it, and opcode 0 changes nothing. Reading a control register returns the flag in bit 0 and zeros above it.
- R3: Opcode 1 copies the path's control value (the flag in bit 0) into the low read-data word and sets that path's readiness code to 1.
- R4: With the path's flag clear, a host write to that path's space asserts `tgt_wr` for that cycle, with `tgt_addr` = `host_addr[AW-3:0]` and `tgt_wdata` = `host_wdata`. `tgt_rd` stays low.
- R5: With the path's flag set, such a write asserts `tgt_rd` instead of `tgt_wr`. `tgt_addr` carries the register address and `tgt_tag` = {path bit, new sequence value}, and the path's readiness code drops to 0 at the next edge.
- R6: A response with `tgt_rsp_vld` whose tag matches the newest request of its path loads `tgt_rsp_data` into the read-data register. The readiness code becomes 1 when `tgt_rsp_dbl` is 0 and 3 when it is 1. The code never takes the value 2.
- R7: The status word is at local offset 0. Bits DW-1:DW-2 hold the unbuffered readiness code, bits DW-3:DW-4 hold the buffered one, and all other bits read 0.
- R8: The read-data words sit at local offsets 4/5 (buffered low/high) and 6/7 (unbuffered low/high). Reading the low word clears a code of 1. Reading the high word clears a code of 3. Reading the low word leaves a code of 3 untouched.
- R9: A new indirect read issued while a request is pending, or while data is ready, restarts the readiness code. A response carrying the tag of a superseded request changes neither the code nor the data.
- R10: Host writes to the status word or to any read-data word have no effect.
- R11: The two paths are independent: each has its own mode flag, read-data register and readiness code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (a read of a read-data word may clear readiness) |
| host_addr | input | AW | Host address |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, valid in the cycle `host_rd` is high |
| tgt_wr | output | 1 | Internal register write strobe |
| tgt_rd | output | 1 | Internal register read request |
| tgt_addr | output | AW-2 | Internal register address |
| tgt_wdata | output | DW | Internal register write data |
| tgt_tag | output | SEQW+1 | Request tag {path, sequence} |
| tgt_rsp_vld | input | 1 | Read response valid |
| tgt_rsp_tag | input | SEQW+1 | Tag of the response |
| tgt_rsp_dbl | input | 1 | Response is a double word |
| tgt_rsp_data | input | 2*DW | Response data, low word in the low half |

## Verification
The bench builds the block with its defaults: AW=16, DW=32 and SEQW=2. With these values the status fields sit at bits 31:30 and 29:28, and the paths are selected by address bit 14. Because the sequence count is only two bits wide, a short run of indirect reads and self-reads wraps it. This lets the bench exercise tag matching across a wrap. The bench acts as the internal register port and chooses both when each response arrives and which tag it carries, so stale responses and double-word replies can be produced on demand.

// File: rtl/iru_pkg.sv
package iru_pkg;

    typedef enum logic [1:0] {
        OP_NOP       = 2'd0,
        OP_SELF_READ = 2'd1,
        OP_MODE_CLR  = 2'd2,
        OP_MODE_SET  = 2'd3
    } iru_op_e;

    localparam logic [1:0] RDY_NONE   = 2'd0;
    localparam logic [1:0] RDY_SINGLE = 2'd1;
    localparam logic [1:0] RDY_DOUBLE = 2'd3;

    localparam logic [2:0] LOC_STATUS = 3'd0;
    localparam logic [2:0] LOC_CTL0   = 3'd1;
    localparam logic [2:0] LOC_RD0    = 3'd4;

    localparam int NPATH = 2;

endpackage

// File: rtl/iru_path.sv
module iru_path
    import iru_pkg::*;
#(
    parameter int DW   = 32,
    parameter int SEQW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  iru_op_e           ctl_op,
    input  logic              tgt_hit,
    input  logic              rsp_vld,
    input  logic [SEQW-1:0]   rsp_seq,
    input  logic              rsp_dbl,
    input  logic [2*DW-1:0]   rsp_data,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic              issue,
    output logic [SEQW-1:0]   issue_seq,
    output logic              wtr,
    output logic [1:0]        rdy,
    output logic [2*DW-1:0]   rdata
);

    typedef struct packed {
        logic            wtr;
        logic [SEQW-1:0] seq;
        logic [1:0]      rdy;
        logic [2*DW-1:0] data;
    } path_st_t;

    path_st_t st_d, st_q;
    logic     capture;

    always_comb begin
        st_d      = st_q;
        issue     = 1'b0;
        issue_seq = st_q.seq + SEQW'(1);
        capture   = rsp_vld && (rsp_seq == st_q.seq);

        if (capture) begin
            st_d.data = rsp_data;
            st_d.rdy  = rsp_dbl ? RDY_DOUBLE : RDY_SINGLE;
        end else begin
            if (rd_lo && st_q.rdy == RDY_SINGLE) st_d.rdy = RDY_NONE;
            if (rd_hi && st_q.rdy == RDY_DOUBLE) st_d.rdy = RDY_NONE;
        end

        if (ctl_we) begin
            case (ctl_op)
                OP_MODE_SET: st_d.wtr = 1'b1;
                OP_MODE_CLR: st_d.wtr = 1'b0;
                OP_SELF_READ: begin
                    st_d.data = {{(2*DW-1){1'b0}}, st_q.wtr};
                    st_d.rdy  = RDY_SINGLE;
                    st_d.seq  = issue_seq;
                end
                default: ;
            endcase
        end

        if (tgt_hit && st_q.wtr) begin
            issue    = 1'b1;
            st_d.seq = issue_seq;
            st_d.rdy = RDY_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wtr   = st_q.wtr;
    assign rdy   = st_q.rdy;
    assign rdata = st_q.data;

    AST_RDY_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rdy != 2'd2); // R6

    AST_ISSUE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (rdy == RDY_NONE)); // R5

    AST_STALE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_seq != st_q.seq && !(ctl_we && ctl_op == OP_SELF_READ))
        |=> $stable(rdata)); // R9

    AST_LO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo && rdy == RDY_SINGLE && !rsp_vld && !ctl_we && !tgt_hit)
        |=> (rdy == RDY_NONE)); // R8

    AST_MODE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_op == OP_MODE_SET) |=> wtr); // R2

endmodule

// File: rtl/wtr_read_unit.sv
module wtr_read_unit
    import iru_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int SEQW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [AW-1:0]     host_addr,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata,
    output logic              tgt_wr,
    output logic              tgt_rd,
    output logic [AW-3:0]     tgt_addr,
    output logic [DW-1:0]     tgt_wdata,
    output logic [SEQW:0]     tgt_tag,
    input  logic              tgt_rsp_vld,
    input  logic [SEQW:0]     tgt_rsp_tag,
    input  logic              tgt_rsp_dbl,
    input  logic [2*DW-1:0]   tgt_rsp_data
);

    localparam int TAGW = SEQW + 1;

    logic       unit_sel;
    logic       path_sel;
    logic [2:0] loc;

    logic [NPATH-1:0] wtr_v;
    logic [NPATH-1:0] issue_v;
    logic [SEQW-1:0]  iseq   [NPATH];
    logic [1:0]       rdy    [NPATH];
    logic [2*DW-1:0]  rdat   [NPATH];

    assign unit_sel = host_addr[AW-1];
    assign path_sel = host_addr[AW-2];
    assign loc      = host_addr[2:0];

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        logic ctl_we, tgt_hit, rsp_vld, rd_lo, rd_hi;

        assign ctl_we  = host_wr && unit_sel  && loc == 3'(LOC_CTL0 + p);
        assign tgt_hit = host_wr && !unit_sel && path_sel == 1'(p);
        assign rsp_vld = tgt_rsp_vld && tgt_rsp_tag[TAGW-1] == 1'(p);
        assign rd_lo   = host_rd && unit_sel  && loc == 3'(LOC_RD0 + 2*p);
        assign rd_hi   = host_rd && unit_sel  && loc == 3'(LOC_RD0 + 2*p + 1);

        iru_path #(.DW(DW), .SEQW(SEQW)) u_path (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl_we    (ctl_we),
            .ctl_op    (iru_op_e'(host_wdata[2:1])),
            .tgt_hit   (tgt_hit),
            .rsp_vld   (rsp_vld),
            .rsp_seq   (tgt_rsp_tag[SEQW-1:0]),
            .rsp_dbl   (tgt_rsp_dbl),
            .rsp_data  (tgt_rsp_data),
            .rd_lo     (rd_lo),
            .rd_hi     (rd_hi),
            .issue     (issue_v[p]),
            .issue_seq (iseq[p]),
            .wtr       (wtr_v[p]),
            .rdy       (rdy[p]),
            .rdata     (rdat[p])
        );
    end

    assign tgt_wr    = host_wr && !unit_sel && !wtr_v[path_sel];
    assign tgt_rd    = |issue_v;
    assign tgt_addr  = host_addr[AW-3:0];
    assign tgt_wdata = host_wdata;
    assign tgt_tag   = {path_sel, iseq[path_sel]};

    always_comb begin
        host_rdata = '0;
        if (host_rd && unit_sel) begin
            case (loc)
                LOC_STATUS: begin
                    host_rdata[DW-1:DW-2] = rdy[1];
                    host_rdata[DW-3:DW-4] = rdy[0];
                end
                3'd1:    host_rdata[0] = wtr_v[0];
                3'd2:    host_rdata[0] = wtr_v[1];
                3'd4:    host_rdata = rdat[0][DW-1:0];
                3'd5:    host_rdata = rdat[0][2*DW-1:DW];
                3'd6:    host_rdata = rdat[1][DW-1:0];
                3'd7:    host_rdata = rdat[1][2*DW-1:DW];
                default: host_rdata = '0;
            endcase
        end
    end

    AST_PASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |-> !tgt_rd); // R4

    AST_WRITE_SILENT_IN_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && unit_sel) |-> !(tgt_wr || tgt_rd)); // R10

endmodule

// File: tb/sim_wtr_read_unit.sv
module sim_wtr_read_unit;

    localparam int AW   = 16;
    localparam int DW   = 32;
    localparam int SEQW = 2;

    localparam logic [15:0] U_STATUS = 16'h8000;
    localparam logic [15:0] U_CTL0   = 16'h8001;
    localparam logic [15:0] U_CTL1   = 16'h8002;
    localparam logic [15:0] U_RD0LO  = 16'h8004;
    localparam logic [15:0] U_RD0HI  = 16'h8005;
    localparam logic [15:0] U_RD1LO  = 16'h8006;
    localparam logic [15:0] U_RD1HI  = 16'h8007;
    localparam logic [15:0] T_BUF    = 16'h0000;
    localparam logic [15:0] T_UNBUF  = 16'h4000;

    localparam logic [31:0] W_SET  = 32'h6;
    localparam logic [31:0] W_CLR  = 32'h4;
    localparam logic [31:0] W_SELF = 32'h2;

    logic clk = 0;
    logic rst_n = 0;
    logic host_wr = 0, host_rd = 0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic [DW-1:0] host_rdata;
    logic tgt_wr, tgt_rd;
    logic [AW-3:0] tgt_addr;
    logic [DW-1:0] tgt_wdata;
    logic [SEQW:0] tgt_tag;
    logic tgt_rsp_vld = 0;
    logic [SEQW:0] tgt_rsp_tag = '0;
    logic tgt_rsp_dbl = 0;
    logic [2*DW-1:0] tgt_rsp_data = '0;

    int checks = 0;
    int failures = 0;

    logic          obs_wr, obs_rd;
    logic [AW-3:0] obs_addr;
    logic [DW-1:0] obs_wdata;
    logic [SEQW:0] obs_tag;

    always #4 clk = ~clk;

    wtr_read_unit #(.AW(AW), .DW(DW), .SEQW(SEQW)) u0 (
        .clk, .rst_n, .host_wr, .host_rd, .host_addr, .host_wdata, .host_rdata,
        .tgt_wr, .tgt_rd, .tgt_addr, .tgt_wdata, .tgt_tag,
        .tgt_rsp_vld, .tgt_rsp_tag, .tgt_rsp_dbl, .tgt_rsp_data
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        #1;
        obs_wr = tgt_wr; obs_rd = tgt_rd; obs_addr = tgt_addr;
        obs_wdata = tgt_wdata; obs_tag = tgt_tag;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic hread(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        host_rd = 1; host_addr = a;
        #1;
        d = host_rdata;
        @(negedge clk);
        host_rd = 0;
    endtask

    task automatic respond(input logic [SEQW:0] tag, input logic dbl,
                           input logic [63:0] data);
        @(negedge clk);
        tgt_rsp_vld = 1; tgt_rsp_tag = tag; tgt_rsp_dbl = dbl; tgt_rsp_data = data;
        @(negedge clk);
        tgt_rsp_vld = 0;
    endtask

    task automatic expect_read(input logic [15:0] a, input logic [31:0] exp,
                               input string req);
        logic [31:0] v;
        hread(a, v);
        check(v == exp, req, 64'(v), 64'(exp));
    endtask

    task automatic t_reset;
        expect_read(U_STATUS, 32'h0, "R1 status after reset");
        expect_read(U_CTL0,   32'h0, "R1 buffered flag after reset");
        expect_read(U_CTL1,   32'h0, "R1 unbuffered flag after reset");
        expect_read(U_RD0LO,  32'h0, "R1 read data after reset");
        expect_read(U_RD1HI,  32'h0, "R1 read data hi after reset");
    endtask

    task automatic t_mode;
        hwrite(U_CTL0, W_SET);
        expect_read(U_CTL0, 32'h1, "R2 opcode 3 sets flag");
        hwrite(U_CTL0, 32'hFFFF_FFF9);
        expect_read(U_CTL0, 32'h1, "R2 opcode 0 no change");
        expect_read(U_CTL1, 32'h0, "R11 other path flag untouched");
        hwrite(U_STATUS, 32'hFFFF_FFFF);
        hwrite(U_RD0LO,  32'hFFFF_FFFF);
        expect_read(U_STATUS, 32'h0, "R10 status write ignored");
        expect_read(U_RD0LO,  32'h0, "R10 read-data write ignored");
    endtask

    task automatic t_self_read;
        hwrite(U_CTL0, W_SELF);
        expect_read(U_STATUS, 32'h1000_0000, "R3 R7 self read single ready");
        expect_read(U_RD0LO,  32'h1, "R3 self read value");
        expect_read(U_STATUS, 32'h0, "R8 low read clears single");
    endtask

    task automatic t_passthru;
        hwrite(T_UNBUF | 16'h0123, 32'hABCD_0001);
        check(obs_wr && !obs_rd, "R4 pass-through strobes", {62'b0, obs_wr, obs_rd}, 64'h2);
        check(obs_addr == 14'h0123, "R4 pass-through address", 64'(obs_addr), 64'h123);
        check(obs_wdata == 32'hABCD_0001, "R4 pass-through data", 64'(obs_wdata), 64'hABCD0001);
    endtask

    task automatic t_single;
        logic [SEQW:0] tg;
        hwrite(T_BUF | 16'h0045, 32'hFFFF_FFFF);
        tg = obs_tag;
        check(obs_rd && !obs_wr, "R5 indirect strobes", {62'b0, obs_wr, obs_rd}, 64'h1);
        check(obs_addr == 14'h0045, "R5 indirect address", 64'(obs_addr), 64'h45);
        check(tg[SEQW] == 1'b0, "R11 buffered tag path bit", 64'(tg), 64'h0);
        expect_read(U_STATUS, 32'h0, "R5 pending shows not ready");
        respond(tg, 1'b0, 64'h0000_0000_1234_5678);
        expect_read(U_STATUS, 32'h1000_0000, "R6 single ready code");
        expect_read(U_RD0LO,  32'h1234_5678, "R6 captured single");
        expect_read(U_STATUS, 32'h0, "R8 cleared after low read");
    endtask

    task automatic t_double;
        logic [SEQW:0] tg;
        hwrite(U_CTL1, W_SET);
        expect_read(U_CTL1, 32'h1, "R11 unbuffered flag set");
        hwrite(T_UNBUF | 16'h0010, 32'hFFFF_FFFF);
        tg = obs_tag;
        check(obs_rd && tg[SEQW] == 1'b1, "R11 unbuffered tag path bit", 64'(tg), 64'h4);
        respond(tg, 1'b1, 64'hAAAA_5555_DEAD_BEEF);
        expect_read(U_STATUS, 32'hC000_0000, "R6 R7 double ready code");
        expect_read(U_RD1LO,  32'hDEAD_BEEF, "R6 double low word");
        expect_read(U_STATUS, 32'hC000_0000, "R8 low read keeps double");
        expect_read(U_RD1HI,  32'hAAAA_5555, "R6 double high word");
        expect_read(U_STATUS, 32'h0, "R8 high read clears double");
    endtask

    task automatic t_overwrite;
        logic [SEQW:0] ta, tb, tc;
        hwrite(T_BUF | 16'h0001, 32'hFFFF_FFFF);
        ta = obs_tag;
        hwrite(T_BUF | 16'h0002, 32'hFFFF_FFFF);
        tb = obs_tag;
        check(ta != tb, "R9 new request new tag", 64'(tb), 64'(ta));
        respond(ta, 1'b0, 64'h111);
        expect_read(U_STATUS, 32'h0, "R9 stale response ignored");
        respond(tb, 1'b0, 64'h222);
        expect_read(U_STATUS, 32'h1000_0000, "R9 newest response ready");
        hwrite(T_BUF | 16'h0003, 32'hFFFF_FFFF);
        tc = obs_tag;
        expect_read(U_STATUS, 32'h0, "R9 new read restarts readiness");
        respond(tb, 1'b1, 64'h999);
        expect_read(U_STATUS, 32'h0, "R9 old tag after restart ignored");
        respond(tc, 1'b0, 64'h333);
        expect_read(U_RD0LO, 32'h333, "R9 overwrite result");
    endtask

    task automatic t_clear_mode;
        hwrite(U_CTL0, W_CLR);
        expect_read(U_CTL0, 32'h0, "R2 opcode 2 clears flag");
        hwrite(T_BUF | 16'h0077, 32'h5);
        check(obs_wr && !obs_rd, "R4 pass-through after clear", {62'b0, obs_wr, obs_rd}, 64'h2);
        expect_read(U_CTL1, 32'h1, "R11 unbuffered flag still set");
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_mode();
        t_self_read();
        t_passthru();
        t_single();
        t_double();
        t_overwrite();
        t_clear_mode();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule